// File: doc/BRIEF.md
# Two's-Complement Adder-Subtractor with Three-Way Compare

This block is a purely combinational N-bit arithmetic unit. It either adds operand B to operand A or subtracts B from A. Alongside the result it gives four condition codes: carry/borrow, zero, negative and overflow. Subtraction uses the same ripple of full-adder cells as addition. B is inverted bit by bit and the chain's carry-in is forced to one.

The block also relates A to B as equal, less or greater. It does this in a second adder path that always forms A minus B. The relation comes only from that path's condition codes, read as signed or unsigned numbers depending on a mode input. The relation outputs do not depend on the add/subtract select. A surrounding datapath can therefore add and compare in the same cycle.

Top module: `radix_addsub_cmp`

## Requirements
- R1: With subSel=0, sumOut equals (opA + opB) modulo 2^WIDTH. The carry out of the top bit does not enter the sum.
- R2: With subSel=1, sumOut equals (opA - opB) modulo 2^WIDTH.
- R3: flagV is 1 exactly when the signed result of the selected operation does not fit in WIDTH bits. Adding operands whose sign bits differ never sets flagV.
- R4: With subSel=0, flagC is the carry out of the top bit: 1 exactly when opA + opB, read as unsigned values, reaches 2^WIDTH.
- R5: With subSel=1, flagC is a borrow: 1 exactly when opA < opB as unsigned values. For example, 0-1 gives flagC=1 and 1-0 gives flagC=0.
- R6: flagN equals the top bit (bit WIDTH-1) of sumOut, and flagZ is 1 exactly when every bit of sumOut is 0.
- R7: relEq is 1 exactly when opA equals opB, in either mode.
- R8: With signedMode=1, relLt and relGt follow the two's-complement order. For 2-bit operands, 00 against 10 gives relGt=1.
- R9: With signedMode=0, relLt and relGt follow the unsigned order.
- R10: Exactly one of relEq, relLt and relGt is 1 at all times, and subSel has no effect on any of the three.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand (minuend when subtracting) |
| opB | input | WIDTH | Second operand (subtrahend when subtracting) |
| subSel | input | 1 | 1 selects A-B, 0 selects A+B |
| signedMode | input | 1 | 1 compares as two's complement, 0 as unsigned |
| sumOut | output | WIDTH | Sum or difference |
| flagC | output | 1 | Carry out when adding, borrow when subtracting |
| flagZ | output | 1 | Result is all zeros |
| flagN | output | 1 | Top bit of the result |
| flagV | output | 1 | Signed overflow |
| relEq | output | 1 | opA equals opB |
| relLt | output | 1 | opA below opB in the chosen mode |
| relGt | output | 1 | opA above opB in the chosen mode |

## Verification
The block holds no state, so a fault shows at the ports in the same evaluation as the stimulus that exposes it. Faults such as a broken carry link, a wrong carry-in or a flipped borrow sense usually appear in only some operand pairs. For that reason every pair at width 4 is driven in both operations and both compare modes, and each output is checked against an integer model. A wrong signed/unsigned selection in the compare path shows only for pairs whose top bits differ. The sweep covers all of those pairs.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  // Strobes the control issues to one adder path.
  typedef struct packed {
    logic invertB;     // complement the second operand
    logic carryIn;     // carry into bit 0
    logic borrowFlag;  // report an inverted carry out as a borrow
  } adderStrobes_t;

  // Condition codes produced by one adder path.
  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } condCodes_t;
endpackage

// File: rtl/addsub_fa_cell.sv
module addsub_fa_cell (
  input  logic x,
  input  logic y,
  input  logic cIn,
  output logic s,
  output logic cOut
);
  logic prop;
  logic gen;

  always_comb begin
    prop = x ^ y;
    gen  = x & y;
    s    = prop ^ cIn;
    cOut = gen | (prop & cIn);
  end
endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  adderStrobes_t    strobes,
  output logic [WIDTH-1:0] sum,
  output condCodes_t       codes
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH:0]   carry;

  assign bEff     = opB ^ {WIDTH{strobes.invertB}};
  assign carry[0] = strobes.carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    addsub_fa_cell u_fa (
      .x    (opA[i]),
      .y    (bEff[i]),
      .cIn  (carry[i]),
      .s    (sum[i]),
      .cOut (carry[i+1])
    );
  end

  always_comb begin
    codes.c = carry[WIDTH] ^ strobes.borrowFlag;
    codes.z = ~|sum;
    codes.n = sum[MSB];
    codes.v = carry[WIDTH] ^ carry[MSB];
  end
endmodule

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
(
  input  logic          subSel,
  input  logic          signedMode,
  output adderStrobes_t mainStrobes,
  output adderStrobes_t cmpStrobes,
  output logic          signedCmp
);
  always_comb begin
    mainStrobes.invertB    = subSel;
    mainStrobes.carryIn    = subSel;
    mainStrobes.borrowFlag = subSel;
    // The compare path always forms A-B.
    cmpStrobes.invertB     = 1'b1;
    cmpStrobes.carryIn     = 1'b1;
    cmpStrobes.borrowFlag  = 1'b1;
    signedCmp              = signedMode;
  end
endmodule

// File: rtl/addsub_relation.sv
module addsub_relation
  import addsub_pkg::*;
(
  input  condCodes_t diffCodes,
  input  logic       signedCmp,
  output logic       isEq,
  output logic       isLt,
  output logic       isGt
);
  logic ltSigned;
  logic ltUnsigned;

  always_comb begin
    ltSigned   = diffCodes.n ^ diffCodes.v;
    ltUnsigned = diffCodes.c;
    isEq       = diffCodes.z;
    isLt       = signedCmp ? ltSigned : ltUnsigned;
    isGt       = ~isLt & ~isEq;
  end
endmodule

// File: rtl/radix_addsub_cmp.sv
module radix_addsub_cmp
  import addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             subSel,
  input  logic             signedMode,
  output logic [WIDTH-1:0] sumOut,
  output logic             flagC,
  output logic             flagZ,
  output logic             flagN,
  output logic             flagV,
  output logic             relEq,
  output logic             relLt,
  output logic             relGt
);
  adderStrobes_t    mainStrobes;
  adderStrobes_t    cmpStrobes;
  logic             signedCmp;
  condCodes_t       mainCodes;
  condCodes_t       cmpCodes;
  logic [WIDTH-1:0] cmpDiff;

  addsub_ctrl u_ctrl (
    .subSel      (subSel),
    .signedMode  (signedMode),
    .mainStrobes (mainStrobes),
    .cmpStrobes  (cmpStrobes),
    .signedCmp   (signedCmp)
  );

  addsub_datapath #(.WIDTH(WIDTH)) u_mainPath (
    .opA     (opA),
    .opB     (opB),
    .strobes (mainStrobes),
    .sum     (sumOut),
    .codes   (mainCodes)
  );

  addsub_datapath #(.WIDTH(WIDTH)) u_cmpPath (
    .opA     (opA),
    .opB     (opB),
    .strobes (cmpStrobes),
    .sum     (cmpDiff),
    .codes   (cmpCodes)
  );

  addsub_relation u_rel (
    .diffCodes (cmpCodes),
    .signedCmp (signedCmp),
    .isEq      (relEq),
    .isLt      (relLt),
    .isGt      (relGt)
  );

  // The difference value itself is not brought out; only its codes matter.
  logic unusedDiff;
  assign unusedDiff = ^cmpDiff;

  assign flagC = mainCodes.c;
  assign flagZ = mainCodes.z;
  assign flagN = mainCodes.n;
  assign flagV = mainCodes.v;
endmodule

// File: rtl/radix_addsub_cmp_chk.sv
module radix_addsub_cmp_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             subSel,
  input logic             signedMode,
  input logic [WIDTH-1:0] sumOut,
  input logic             flagC,
  input logic             flagV,
  input logic             relEq,
  input logic             relLt,
  input logic             relGt
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] wideSum;
  assign wideSum = {1'b0, opA} + {1'b0, opB};

  always_comb begin
    assert_sum_R1: assert (subSel || sumOut == wideSum[MSB:0]);
    assert_no_overflow_R3: assert (subSel || opA[MSB] == opB[MSB] || !flagV);
    assert_carry_R4: assert (subSel || flagC == wideSum[WIDTH]);
    assert_borrow_R5: assert (!subSel || flagC == (opA < opB));
    assert_equal_R7: assert (relEq == (opA == opB));
    assert_signed_lt_R8: assert (!signedMode || relLt == ($signed(opA) < $signed(opB)));
    assert_unsigned_lt_R9: assert (signedMode || relLt == (opA < opB));
    assert_one_relation_R10: assert ($countones({relEq, relLt, relGt}) == 1);
  end
endmodule

bind radix_addsub_cmp radix_addsub_cmp_chk #(.WIDTH(WIDTH)) u_chk (
  .opA        (opA),
  .opB        (opB),
  .subSel     (subSel),
  .signedMode (signedMode),
  .sumOut     (sumOut),
  .flagC      (flagC),
  .flagV      (flagV),
  .relEq      (relEq),
  .relLt      (relLt),
  .relGt      (relGt)
);

// File: tb/sim_radix_addsub_cmp.sv
`timescale 1ns/1ps
module sim_radix_addsub_cmp;
  localparam int W = 4;
  localparam int SPAN = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0] opA, opB, sumOut;
  logic subSel, signedMode;
  logic flagC, flagZ, flagN, flagV, relEq, relLt, relGt;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  radix_addsub_cmp #(.WIDTH(W)) u0 (
    .opA(opA), .opB(opB), .subSel(subSel), .signedMode(signedMode),
    .sumOut(sumOut), .flagC(flagC), .flagZ(flagZ), .flagN(flagN),
    .flagV(flagV), .relEq(relEq), .relLt(relLt), .relGt(relGt)
  );

  task automatic chk(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s A=%0d B=%0d sub=%0d sgn=%0d actual=%0d expected=%0d",
               req, opA, opB, subSel, signedMode, act, exp);
    end
  endtask

  task automatic drive(input int a, input int b, input bit s, input bit m);
    @(negedge clk);
    opA = W'(a); opB = W'(b); subSel = s; signedMode = m;
    #2;
  endtask

  // Integer reference model and full output check.
  task automatic checkAll(input int ua, input int ub, input bit s, input bit m);
    int sa, sb, full, sfull, res, expLt;
    sa = (ua >= SPAN/2) ? ua - SPAN : ua;
    sb = (ub >= SPAN/2) ? ub - SPAN : ub;
    full  = s ? ua - ub : ua + ub;
    sfull = s ? sa - sb : sa + sb;
    res   = (full + SPAN) % SPAN;
    drive(ua, ub, s, m);
    chk(s ? "R2" : "R1", int'(sumOut), res);
    chk("R3", int'(flagV), int'(sfull > SPAN/2 - 1 || sfull < -SPAN/2));
    if (s) chk("R5", int'(flagC), int'(ua < ub));
    else   chk("R4", int'(flagC), int'(full >= SPAN));
    chk("R6", int'(flagN), int'(res >= SPAN/2));
    chk("R6", int'(flagZ), int'(res == 0));
    chk("R7", int'(relEq), int'(ua == ub));
    expLt = m ? int'(sa < sb) : int'(ua < ub);
    chk(m ? "R8" : "R9", int'(relLt), expLt);
    chk(m ? "R8" : "R9", int'(relGt), int'(!expLt && ua != ub));
    chk("R10", int'(relEq) + int'(relLt) + int'(relGt), 1);
  endtask

  task automatic tReset();
    drive(0, 0, 1'b0, 1'b0);
    chk("R1", int'(sumOut), 0);
    chk("R6", int'(flagZ), 1);
    chk("R7", int'(relEq), 1);
  endtask

  task automatic tCorners();
    drive(7, 1, 1'b0, 1'b1);  chk("R3", int'(flagV), 1);
    drive(8, 15, 1'b0, 1'b1); chk("R3", int'(flagV), 1);
    chk("R4", int'(flagC), 1);
    drive(7, 8, 1'b0, 1'b1);  chk("R3", int'(flagV), 0);
    drive(0, 1, 1'b1, 1'b0);  chk("R5", int'(flagC), 1);
    drive(1, 0, 1'b1, 1'b0);  chk("R5", int'(flagC), 0);
    drive(0, 8, 1'b1, 1'b1);  chk("R8", int'(relGt), 1);
    chk("R5", int'(flagC), 1); chk("R6", int'(flagN), 1);
    chk("R3", int'(flagV), 1);
    drive(0, 8, 1'b1, 1'b0);  chk("R9", int'(relLt), 1);
  endtask

  task automatic tSubIgnored();
    for (int a = 0; a < SPAN; a += 3) begin
      for (int b = 0; b < SPAN; b += 5) begin
        for (int m = 0; m < 2; m++) begin
          logic [2:0] r0;
          drive(a, b, 1'b0, m[0]); r0 = {relEq, relLt, relGt};
          drive(a, b, 1'b1, m[0]);
          chk("R10", int'({relEq, relLt, relGt}), int'(r0));
        end
      end
    end
  endtask

  task automatic tExhaustive();
    for (int a = 0; a < SPAN; a++)
      for (int b = 0; b < SPAN; b++)
        for (int k = 0; k < 4; k++)
          checkAll(a, b, k[0], k[1]);
  endtask

  initial begin
    opA = '0; opB = '0; subSel = 1'b0; signedMode = 1'b0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    tReset();
    tCorners();
    tSubIgnored();
    tExhaustive();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule